// File: doc/BRIEF.md
# SPI Register Access Slave

This block is a four-wire serial slave that gives a host access to a 64-address register space. Every transaction opens with a header byte. The header carries a direction flag, a burst flag and a six-bit address. Ordinary addresses move one data byte, or a run of data bytes, between the host and an external register file. The top sixteen addresses do not hold registers. They are dataless commands, and the block passes each one to the rest of the chip as a single-cycle pulse that carries the command code.

The block runs on the system clock. Chip select, serial clock and serial data in each go through a two-flop synchroniser, and edges of the serial clock are found in the system-clock domain. While each header byte shifts in, the block shifts a status byte out. That byte comes from a parallel input, and its top bit is the not-ready flag.

The controller has five states:
- `ST_IDLE`: chip select is high.
- `ST_HEADER`: waiting for a header byte.
- `ST_WRITE`: taking data bytes into registers.
- `ST_READ`: returning register contents.
- `ST_DISCARD`: ignoring the rest of a transaction.

The transitions are:
- idle→header when chip select falls.
- header→write for a write header, and header→read for a read header.
- header→header after a command code.
- header→discard on the direct-FIFO code.
- write→header and read→header after the single data byte of a non-burst access.
- Write and read stay put while a burst runs.
- Any state→idle when chip select rises.

Top module: `spi_regslave`

## Requirements
- R1: Every byte in both directions is sent most significant bit first. The input is sampled on a rising serial-clock edge, and the output changes only on a falling edge.
- R2: During every header byte, and during every write data byte, the output carries `status_in` as captured at the start of that byte. Bit 7 of `status_in` (the not-ready flag) is passed through unchanged.
- R3: Header bit 7 selects a read when it is 1 and a write when it is 0. Bit 6 is the burst flag. Bits 5:0 are the address.
- R4: A write header with burst clear and an address from 0x00 to 0x2F writes exactly one data byte to that address. The byte after it is taken as a new header.
- R5: A read header with burst clear and an address from 0x00 to 0x2F returns the register at that address in the next byte. The byte after that is a new header.
- R6: A burst write stores each data byte at an address one higher than the byte before. This continues until chip select rises.
- R7: A burst read returns the registers at consecutive addresses, one per byte, until chip select rises.
- R8: In a burst, the address that follows 0x2F is 0x00.
- R9: A header with an address from 0x30 to 0x3F, other than 0x3E, takes no data byte. It raises `strobe_valid` for one cycle with the address on `strobe_code`, so 0x3B (transmit-buffer flush), 0x3C (wake-timer reset) and 0x3D (no-op) each come out unchanged. The next byte is a new header.
- R10: Header address 0x3E makes no register access and no command pulse. All later bytes of that transaction are ignored and return 0x00.
- R11: When chip select rises, any partly received byte is dropped and the transaction ends. The next transaction starts with a header.
- R12: `reg_we` and `strobe_valid` are each single-cycle pulses and are never high together. After reset both are low and `spi_miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| status_in | input | 8 | Status byte returned with headers; bit 7 is not-ready |
| reg_addr | output | 6 | Register file address |
| reg_wdata | output | 8 | Register file write data |
| reg_we | output | 1 | Register file write pulse |
| reg_rdata | input | 8 | Register file read data for `reg_addr` |
| strobe_valid | output | 1 | One-cycle command pulse |
| strobe_code | output | 6 | Command code, valid with `strobe_valid` |

## Verification
On every cycle, the embedded properties check four things:
- The write pulse and the command pulse never overlap.
- Each pulse lasts one cycle.
- Command codes stay inside the command range and never equal the FIFO code.
- Writes only reach register addresses.

Only the directed scenarios can show the byte-level behaviour. That covers:
- The status byte appearing under each header.
- The order in which burst addresses step, and where they wrap.
- Read data arriving in the correct byte.
- An aborted transaction leaving the registers untouched.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_WRITE,
        ST_READ,
        ST_DISCARD
    } ctrl_state_t;

endpackage

// File: rtl/spi_regslave_sync.sv
module spi_regslave_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff_q <= {STAGES{RST_VAL}};
        end else begin
            ff_q <= {ff_q[STAGES-2:0], d};
        end
    end

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/spi_regslave_shift.sv
module spi_regslave_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              ld_now,
    input  logic              ld_next,
    input  logic [DATA_W-1:0] ld_byte,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              miso
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic              sck_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-2:0] rx_sr;
    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] pend_byte;
    logic              pend;
    logic              rise;
    logic              fall;

    assign rise = sck_s & ~sck_d & ~csn_s;
    assign fall = ~sck_s & sck_d & ~csn_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d     <= 1'b0;
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            pend_byte <= '0;
            pend      <= 1'b0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            sck_d     <= sck_s;
            byte_done <= 1'b0;
            if (csn_s) begin
                bit_cnt <= '0;
                tx_sr   <= '0;
                pend    <= 1'b0;
            end else begin
                if (rise) begin
                    rx_sr   <= {rx_sr[DATA_W-3:0], mosi_s};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        byte_done <= 1'b1;
                        rx_byte   <= {rx_sr, mosi_s};
                    end
                end
                if (fall) begin
                    if (pend) begin
                        tx_sr <= pend_byte;
                        pend  <= 1'b0;
                    end else begin
                        tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
                    end
                end
                if (ld_now) begin
                    tx_sr <= ld_byte;
                end else if (ld_next) begin
                    pend_byte <= ld_byte;
                    pend      <= 1'b1;
                end
            end
        end
    end

    assign miso = tx_sr[DATA_W-1];

    p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done)
        else $error("byte_done held longer than one cycle");
endmodule

// File: rtl/spi_regslave_ctrl.sv
module spi_regslave_ctrl
    import spi_regslave_pkg::*;
#(
    parameter int          ADDR_W      = 6,
    parameter int          DATA_W      = 8,
    parameter logic [5:0]  STROBE_BASE = 6'h30,
    parameter logic [5:0]  FIFO_CODE   = 6'h3E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              ld_now,
    output logic              ld_next,
    output logic [DATA_W-1:0] ld_byte,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              strobe_valid,
    output logic [ADDR_W-1:0] strobe_code
);
    localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(STROBE_BASE);
    localparam logic [ADDR_W-1:0] FIFO_A   = ADDR_W'(FIFO_CODE);
    localparam logic [ADDR_W-1:0] REG_LAST = BASE_A - 1'b1;

    ctrl_state_t       state_q, state_d;
    logic              csn_d;
    logic              cs_fall;
    logic              burst_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] hdr_addr;
    logic [ADDR_W-1:0] addr_inc;
    logic              hdr_strobe;
    logic              hdr_fifo;

    assign cs_fall    = csn_d & ~csn_s;
    assign hdr_addr   = rx_byte[ADDR_W-1:0];
    assign hdr_fifo   = (hdr_addr == FIFO_A);
    assign hdr_strobe = (hdr_addr >= BASE_A) && !hdr_fifo;
    assign addr_inc   = (addr_q == REG_LAST) ? '0 : addr_q + 1'b1;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cs_fall) state_d = ST_HEADER;
            ST_HEADER: begin
                if (byte_done) begin
                    if (hdr_fifo)                state_d = ST_DISCARD;
                    else if (hdr_strobe)         state_d = ST_HEADER;
                    else if (rx_byte[DATA_W-1])  state_d = ST_READ;
                    else                         state_d = ST_WRITE;
                end
            end
            ST_WRITE:   if (byte_done && !burst_q) state_d = ST_HEADER;
            ST_READ:    if (byte_done && !burst_q) state_d = ST_HEADER;
            ST_DISCARD: state_d = ST_DISCARD;
            default:    state_d = ST_IDLE;
        endcase
        if (csn_s) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csn_d        <= 1'b1;
            burst_q      <= 1'b0;
            addr_q       <= '0;
            reg_we       <= 1'b0;
            reg_wdata    <= '0;
            strobe_valid <= 1'b0;
            strobe_code  <= '0;
            ld_now       <= 1'b0;
            ld_next      <= 1'b0;
        end else begin
            csn_d        <= csn_s;
            reg_we       <= 1'b0;
            strobe_valid <= 1'b0;
            ld_now       <= cs_fall;
            ld_next      <= 1'b0;
            if (reg_we && burst_q) addr_q <= addr_inc;
            if (byte_done && !csn_s) begin
                unique case (state_q)
                    ST_HEADER: begin
                        addr_q  <= hdr_addr;
                        burst_q <= rx_byte[DATA_W-2];
                        ld_next <= !hdr_fifo;
                        if (hdr_strobe) begin
                            strobe_valid <= 1'b1;
                            strobe_code  <= hdr_addr;
                        end
                    end
                    ST_WRITE: begin
                        reg_we    <= 1'b1;
                        reg_wdata <= rx_byte;
                        ld_next   <= 1'b1;
                    end
                    ST_READ: begin
                        if (burst_q) addr_q <= addr_inc;
                        ld_next <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ld_byte  = (state_q == ST_READ) ? reg_rdata : status_in;
    assign reg_addr = addr_q;

    p_excl_pulses_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && strobe_valid))
        else $error("write and command pulse overlap");
    p_strobe_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_valid |=> !strobe_valid)
        else $error("command pulse longer than one cycle");
    p_we_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we)
        else $error("write pulse longer than one cycle");
    p_strobe_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_valid |-> (strobe_code >= BASE_A) && (strobe_code != FIFO_A))
        else $error("command code outside command range");
    p_we_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> reg_addr <= REG_LAST)
        else $error("write to non-register address");
    p_discard_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISCARD) |=> !strobe_valid && !reg_we)
        else $error("activity during discarded transaction");
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave #(
    parameter int         ADDR_W      = 6,
    parameter int         DATA_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] STROBE_BASE = 6'h30,
    parameter logic [5:0] FIFO_CODE   = 6'h3E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_csn,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [DATA_W-1:0] status_in,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              strobe_valid,
    output logic [ADDR_W-1:0] strobe_code
);
    localparam int         N_SYNC   = 3;
    localparam logic [2:0] SYNC_RST = 3'b001;

    logic [N_SYNC-1:0] raw_in;
    logic [N_SYNC-1:0] sync_out;
    logic              byte_done;
    logic [DATA_W-1:0] rx_byte;
    logic              ld_now;
    logic              ld_next;
    logic [DATA_W-1:0] ld_byte;

    assign raw_in = {spi_mosi, spi_sck, spi_csn};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        spi_regslave_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (SYNC_RST[g])
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_in[g]),
            .q     (sync_out[g])
        );
    end

    spi_regslave_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .csn_s     (sync_out[0]),
        .sck_s     (sync_out[1]),
        .mosi_s    (sync_out[2]),
        .ld_now    (ld_now),
        .ld_next   (ld_next),
        .ld_byte   (ld_byte),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso      (spi_miso)
    );

    spi_regslave_ctrl #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .STROBE_BASE (STROBE_BASE),
        .FIFO_CODE   (FIFO_CODE)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .csn_s        (sync_out[0]),
        .byte_done    (byte_done),
        .rx_byte      (rx_byte),
        .status_in    (status_in),
        .reg_rdata    (reg_rdata),
        .ld_now       (ld_now),
        .ld_next      (ld_next),
        .ld_byte      (ld_byte),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_we       (reg_we),
        .strobe_valid (strobe_valid),
        .strobe_code  (strobe_code)
    );
endmodule

// File: tb/spi_regslave_tb.sv
module spi_regslave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_csn = 1'b1;
    logic       spi_sck = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic [7:0] status_in = 8'h00;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    logic       strobe_valid;
    logic [5:0] strobe_code;

    int         n_checks = 0;
    int         n_fail = 0;
    int         we_cnt = 0;
    int         stb_cnt = 0;
    logic [5:0] stb_log [0:7];
    logic [7:0] mem [0:63];
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regslave u_dut (
        .clk (clk), .rst_n (rst_n), .spi_csn (spi_csn), .spi_sck (spi_sck),
        .spi_mosi (spi_mosi), .spi_miso (spi_miso), .status_in (status_in),
        .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_we (reg_we),
        .reg_rdata (reg_rdata), .strobe_valid (strobe_valid), .strobe_code (strobe_code)
    );

    function automatic logic [7:0] init_val(int a);
        return 8'((a * 7) + 8'h11);
    endfunction

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
        end else begin
            if (reg_we) begin
                mem[reg_addr] <= reg_wdata;
                we_cnt <= we_cnt + 1;
            end
            if (strobe_valid) begin
                stb_log[stb_cnt[2:0]] <= strobe_code;
                stb_cnt <= stb_cnt + 1;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cs_low();
        @(negedge clk) spi_csn = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (HALF) @(negedge clk);
        spi_csn = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk) spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic t_reset();
        check("R12 reset miso", int'(spi_miso), 0);
        check("R12 reset reg_we", int'(reg_we), 0);
        check("R12 reset strobe", int'(strobe_valid), 0);
    endtask

    task automatic t_single();
        logic [7:0] rx;
        int w0 = we_cnt;
        status_in = 8'h8A;
        cs_low();
        xfer(8'h05, rx);  check("R2 R1 status on write header", rx, 8'h8A);
        xfer(8'h3C, rx);  check("R2 status on write data", rx, 8'h8A);
        xfer(8'h85, rx);  check("R4 next byte is header", rx, 8'h8A);
        xfer(8'h00, rx);  check("R5 R3 single read data", rx, 8'h3C);
        cs_high();
        check("R4 one write pulse", we_cnt - w0, 1);
        check("R4 stored value", mem[5], 8'h3C);
        status_in = 8'h41;
        cs_low();
        xfer(8'h90, rx);  check("R2 status bit7 clear", rx, 8'h41);
        xfer(8'h00, rx);  check("R5 read untouched reg", rx, init_val(16));
        cs_high();
    endtask

    task automatic t_burst();
        logic [7:0] rx;
        int w0 = we_cnt;
        status_in = 8'h13;
        cs_low();
        xfer(8'h48, rx);
        xfer(8'hA1, rx);
        xfer(8'hB2, rx);
        xfer(8'hC3, rx);
        cs_high();
        check("R6 burst write count", we_cnt - w0, 3);
        check("R6 burst addr 8", mem[8], 8'hA1);
        check("R6 burst addr 9", mem[9], 8'hB2);
        check("R6 burst addr 10", mem[10], 8'hC3);
        check("R6 addr 11 untouched", mem[11], init_val(11));
        cs_low();
        xfer(8'hC8, rx);  check("R7 status on burst read header", rx, 8'h13);
        xfer(8'h00, rx);  check("R7 burst read 8", rx, 8'hA1);
        xfer(8'h00, rx);  check("R7 burst read 9", rx, 8'hB2);
        xfer(8'h00, rx);  check("R7 burst read 10", rx, 8'hC3);
        xfer(8'h00, rx);  check("R7 burst read 11", rx, init_val(11));
        cs_high();
    endtask

    task automatic t_wrap();
        logic [7:0] rx;
        cs_low();
        xfer(8'h6E, rx);
        xfer(8'h11, rx);
        xfer(8'h22, rx);
        xfer(8'h33, rx);
        cs_high();
        check("R8 wrap 0x2E", mem[46], 8'h11);
        check("R8 wrap 0x2F", mem[47], 8'h22);
        check("R8 wrap to 0x00", mem[0], 8'h33);
        check("R8 0x30 not a register", mem[48], init_val(48));
        cs_low();
        xfer(8'hEF, rx);
        xfer(8'h00, rx);  check("R8 read 0x2F", rx, 8'h22);
        xfer(8'h00, rx);  check("R8 read wraps 0x00", rx, 8'h33);
        cs_high();
    endtask

    task automatic t_strobes();
        logic [7:0] rx;
        int s0 = stb_cnt;
        int w0 = we_cnt;
        status_in = 8'hC5;
        cs_low();
        xfer(8'h3D, rx);  check("R9 status on nop", rx, 8'hC5);
        xfer(8'h3C, rx);  check("R9 status on wake reset", rx, 8'hC5);
        xfer(8'h7B, rx);  check("R9 status on flush", rx, 8'hC5);
        xfer(8'h02, rx);  check("R9 header after strobes", rx, 8'hC5);
        xfer(8'h5A, rx);
        cs_high();
        check("R9 three pulses", stb_cnt - s0, 3);
        check("R9 code nop", stb_log[s0[2:0]], 8'h3D);
        check("R9 code wake", stb_log[3'(s0 + 1)], 8'h3C);
        check("R9 code flush", stb_log[3'(s0 + 2)], 8'h3B);
        check("R9 write after strobes", mem[2], 8'h5A);
        check("R9 one write", we_cnt - w0, 1);
    endtask

    task automatic t_fifo();
        logic [7:0] rx;
        int s0 = stb_cnt;
        int w0 = we_cnt;
        status_in = 8'h27;
        cs_low();
        xfer(8'h3E, rx);  check("R10 status on fifo header", rx, 8'h27);
        xfer(8'h05, rx);  check("R10 ignored byte 1", rx, 8'h00);
        xfer(8'h77, rx);  check("R10 ignored byte 2", rx, 8'h00);
        cs_high();
        check("R10 no pulse", stb_cnt - s0, 0);
        check("R10 no write", we_cnt - w0, 0);
        check("R10 reg 5 unchanged", mem[5], 8'h3C);
    endtask

    task automatic t_abort();
        logic [7:0] rx;
        int w0 = we_cnt;
        status_in = 8'h66;
        cs_low();
        xfer(8'h4C, rx);
        xfer(8'h9E, rx);
        xfer_bits(8'hF0, 4, rx);
        cs_high();
        check("R11 only complete byte written", we_cnt - w0, 1);
        check("R11 addr 12", mem[12], 8'h9E);
        check("R11 addr 13 untouched", mem[13], init_val(13));
        cs_low();
        xfer_bits(8'h0D, 5, rx);
        cs_high();
        cs_low();
        xfer(8'h8C, rx);  check("R11 fresh header status", rx, 8'h66);
        xfer(8'h00, rx);  check("R11 read after abort", rx, 8'h9E);
        cs_high();
        check("R11 no extra writes", we_cnt - w0, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_single();
        t_burst();
        t_wrap();
        t_strobes();
        t_fifo();
        t_abort();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule